// File: doc/BRIEF.md
# Millisecond Timer Cell with Pulse, On-Delay and Off-Delay Modes

A single timer cell that turns a boolean condition input into a timed boolean output. It also shows how far the timing has got on an elapsed-time output. Time is counted in milliseconds. A prescaler inside the cell divides the system clock down to a 1 ms tick, and the divide ratio comes from the clock-frequency parameter. A test input makes the tick fire on every clock cycle, so that long presets can be exercised quickly.

A two-bit mode input selects one of three behaviours:

- **Pulse:** each qualifying rising edge produces one output pulse of fixed length.
- **On-delay:** the output rises after the condition has been held for the preset time.
- **Off-delay:** the output stays high for the preset time after the condition drops.

The output is a plain registered bit, so other logic can use it directly. The elapsed-time count stops at the preset value and never wraps.

Top module: `tmr_cell`

## Requirements
- R1: While `rstN` is low and on the first cycle after reset, `q` is 0 and `elapsedMs` is 0.
- R2: With `fastTick` at 0, the elapsed count advances at most once every CLK_HZ/1000 clock cycles, where the tick fires on the last count of a free-running divider. With `fastTick` at 1, the tick fires on every cycle.
- R3: The `mode` encoding is 0 = pulse, 1 = on-delay, 2 = off-delay and 3 = disabled. In disabled mode, `q` and `elapsedMs` go to 0 on the next edge, whatever `inSig` does.
- R4: In on-delay mode, `elapsedMs` counts ticks while `inSig` is 1. `q` rises on the edge where `elapsedMs` reaches `presetMs`. An edge that samples `inSig` at 0 clears both `q` and `elapsedMs`.
- R5: In off-delay mode, an edge that samples `inSig` at 1 sets `q` and clears `elapsedMs`. After `inSig` falls, `elapsedMs` counts ticks and `q` drops on the edge where it reaches `presetMs`. `elapsedMs` then holds until `inSig` rises again, and a rise restarts the count from 0.
- R6: In pulse mode, a rising edge of `inSig` seen while `q` is 0 sets `q`. `q` stays at 1 for exactly `presetMs` ticks, while `elapsedMs` counts from 0 up to `presetMs`.
- R7: In pulse mode, rising edges of `inSig` while `q` is 1 are ignored and do not lengthen the pulse. Once the pulse ends, `q` stays 0 until a new rising edge arrives. `elapsedMs` clears when `inSig` is 0 and `q` is 0.
- R8: `elapsedMs` never increments once it is at or above `presetMs`, and it never wraps. If `presetMs` is lowered below the count, the count holds its value.
- R9: With `presetMs` at 0, on-delay mode sets `q` on the first edge that samples `inSig` at 1, and pulse mode produces no pulse at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastTick | input | 1 | Test mode: tick on every clock cycle |
| mode | input | 2 | Timer behaviour select (see R3) |
| inSig | input | 1 | Condition input |
| presetMs | input | PT_W | Preset time in ms |
| q | output | 1 | Timer output bit |
| elapsedMs | output | PT_W | Elapsed time in ms, saturating at the preset |

## Verification
All state is registered. `q` and `elapsedMs` therefore reflect the inputs sampled at a clock edge from that edge onward, exactly one edge after a stimulus. The only exception is slow-tick counting, which advances on the divider's last count. The bench changes inputs on falling edges, updates its reference model on the rising edge and compares 1 ns later, so each comparison sees exactly one edge of effect. Directed checks count the falling edges after a stimulus. For example, a pulse of preset N is seen high on N consecutive samples, and an off-delay of preset N is seen high on N-1 samples after the input falls, because the count and the drop of `q` land on the same edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_PULSE   = 2'd0,
    MODE_ON_DLY  = 2'd1,
    MODE_OFF_DLY = 2'd2,
    MODE_IDLE    = 2'd3
  } tmr_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrEt;
    logic incEt;
  } tmr_strobe_t;

endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000,
  parameter int PT_W   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fastTick,
  input  logic [PT_W-1:0] presetMs,
  input  tmr_strobe_t     strobe,
  output logic            tick,
  output logic            doneNext,
  output logic [PT_W-1:0] elapsedMs
);

  localparam int DIV   = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [PT_W-1:0]  etReg;
  logic [PT_W-1:0]  etNext;

  // free-running millisecond prescaler
  always_ff @(posedge clk) begin
    if (!rstN)                 divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                       divCnt <= divCnt + 1'b1;
  end

  assign tick = fastTick | (divCnt == DIV_LAST);

  // elapsed count with saturation at the preset
  always_comb begin
    etNext = etReg;
    if (strobe.clrEt)                          etNext = '0;
    else if (strobe.incEt && etReg < presetMs) etNext = etReg + 1'b1;
  end

  assign doneNext = (etNext >= presetMs);

  always_ff @(posedge clk) begin
    if (!rstN) etReg <= '0;
    else       etReg <= etNext;
  end

  assign elapsedMs = etReg;

endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  mode,
  input  logic        inSig,
  input  logic        tick,
  input  logic        doneNext,
  output tmr_strobe_t strobe,
  output logic        q
);

  tmr_mode_e modeSel;
  logic      inPrev;
  logic      rise;
  logic      qReg;
  logic      qNext;

  assign modeSel = tmr_mode_e'(mode);
  assign rise    = inSig & ~inPrev;

  // strobes depend only on inputs and held state, never on doneNext
  always_comb begin
    strobe = '0;
    case (modeSel)
      MODE_PULSE: begin
        if (qReg)                strobe.incEt = tick;
        else if (rise || !inSig) strobe.clrEt = 1'b1;
      end
      MODE_ON_DLY: begin
        if (inSig) strobe.incEt = tick;
        else       strobe.clrEt = 1'b1;
      end
      MODE_OFF_DLY: begin
        if (inSig)     strobe.clrEt = 1'b1;
        else if (qReg) strobe.incEt = tick;
      end
      default: strobe.clrEt = 1'b1;
    endcase
  end

  always_comb begin
    case (modeSel)
      MODE_PULSE:   qNext = qReg ? !doneNext : (rise && !doneNext);
      MODE_ON_DLY:  qNext = inSig && doneNext;
      MODE_OFF_DLY: qNext = inSig || (qReg && !doneNext);
      default:      qNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qReg   <= 1'b0;
      inPrev <= 1'b0;
    end else begin
      qReg   <= qNext;
      inPrev <= inSig;
    end
  end

  assign q = qReg;

endmodule

// File: rtl/tmr_cell.sv
module tmr_cell
  import tmr_pkg::*;
#(
  parameter int CLK_HZ = 250_000_000,
  parameter int PT_W   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fastTick,
  input  logic [1:0]      mode,
  input  logic            inSig,
  input  logic [PT_W-1:0] presetMs,
  output logic            q,
  output logic [PT_W-1:0] elapsedMs
);

  tmr_strobe_t strobe;
  logic        tick;
  logic        doneNext;

  tmr_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .inSig    (inSig),
    .tick     (tick),
    .doneNext (doneNext),
    .strobe   (strobe),
    .q        (q)
  );

  tmr_datapath #(.CLK_HZ(CLK_HZ), .PT_W(PT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .fastTick  (fastTick),
    .presetMs  (presetMs),
    .strobe    (strobe),
    .tick      (tick),
    .doneNext  (doneNext),
    .elapsedMs (elapsedMs)
  );

endmodule

// File: rtl/tmr_cell_chk.sv
module tmr_cell_chk #(
  parameter int PT_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            fastTick,
  input logic [1:0]      mode,
  input logic            inSig,
  input logic [PT_W-1:0] presetMs,
  input logic            q,
  input logic [PT_W-1:0] elapsedMs
);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (elapsedMs != $past(elapsedMs) && elapsedMs != '0) |->
      (elapsedMs == $past(elapsedMs) + 1'b1 && $past(elapsedMs) < $past(presetMs))); // R8

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |=> (!q && elapsedMs == '0)); // R3

  AST_ONDLY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1 && !inSig) |=> (!q && elapsedMs == '0)); // R4

  AST_OFFDLY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && inSig) |=> (q && elapsedMs == '0)); // R5

  AST_PULSE_REST: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && !q && !inSig) |=> (!q && elapsedMs == '0)); // R7

  AST_FAST_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (fastTick && mode == 2'd1 && inSig && elapsedMs < presetMs) |=>
      (elapsedMs == $past(elapsedMs) + 1'b1)); // R2

endmodule

bind tmr_cell tmr_cell_chk #(.PT_W(PT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fastTick  (fastTick),
  .mode      (mode),
  .inSig     (inSig),
  .presetMs  (presetMs),
  .q         (q),
  .elapsedMs (elapsedMs)
);

// File: tb/test_tmr_cell.sv
module test_tmr_cell;
  localparam int CLK_HZ = 8000;
  localparam int PT_W   = 8;
  localparam int DIV    = CLK_HZ / 1000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            fastTick = 1'b1;
  logic [1:0]      mode = 2'd1;
  logic            inSig = 1'b0;
  logic [PT_W-1:0] presetMs = 8'd3;
  logic            q;
  logic [PT_W-1:0] elapsedMs;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  tmr_cell #(.CLK_HZ(CLK_HZ), .PT_W(PT_W)) i_tmr_cell (
    .clk(clk), .rstN(rstN), .fastTick(fastTick), .mode(mode),
    .inSig(inSig), .presetMs(presetMs), .q(q), .elapsedMs(elapsedMs)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'd0:    return "R6 pulse model";
      2'd1:    return "R4 on-delay model";
      2'd2:    return "R5 off-delay model";
      default: return "R3 idle model";
    endcase
  endfunction

  // behavioural reference model
  int mEt = 0;
  int mDiv = 0;
  bit mQ = 0;
  bit mPrev = 0;

  always @(posedge clk) begin
    bit tick, clr, inc, rise, done;
    int etN;
    if (!rstN) begin
      mEt = 0; mQ = 0; mPrev = 0; mDiv = 0;
    end else begin
      tick = fastTick || (mDiv == DIV - 1);
      mDiv = (mDiv == DIV - 1) ? 0 : mDiv + 1;
      rise = inSig && !mPrev;
      clr = 0; inc = 0;
      case (mode)
        2'd0: if (mQ) inc = tick; else if (rise || !inSig) clr = 1;
        2'd1: if (inSig) inc = tick; else clr = 1;
        2'd2: if (inSig) clr = 1; else if (mQ) inc = tick;
        default: clr = 1;
      endcase
      if (clr) etN = 0;
      else if (inc && mEt < int'(presetMs)) etN = mEt + 1;
      else etN = mEt;
      done = (etN >= int'(presetMs));
      case (mode)
        2'd0: mQ = mQ ? !done : (rise && !done);
        2'd1: mQ = inSig && done;
        2'd2: mQ = inSig ? 1'b1 : (mQ && !done);
        default: mQ = 0;
      endcase
      mEt = etN;
      mPrev = inSig;
    end
    #1;
    if (rstN && !finished) begin
      check({modeTag(mode), " q"}, int'(q), int'(mQ));
      check({modeTag(mode), " et"}, int'(elapsedMs), mEt);
    end
  end

  initial begin
    int cnt;
    int prevEt;
    step(3);
    check("R1 reset q", int'(q), 0);
    check("R1 reset et", int'(elapsedMs), 0);
    rstN = 1'b1;
    step(1);
    check("R1 first cycle q", int'(q), 0);

    // on-delay
    mode = 2'd1; presetMs = 8'd3; inSig = 1'b1;
    step(1);
    check("R4 et after one tick", int'(elapsedMs), 1);
    check("R4 q not yet", int'(q), 0);
    step(2);
    check("R4 q at preset", int'(q), 1);
    check("R4 et at preset", int'(elapsedMs), 3);
    step(3);
    check("R8 et saturates", int'(elapsedMs), 3);
    inSig = 1'b0;
    step(1);
    check("R4 q cleared", int'(q), 0);
    check("R4 et cleared", int'(elapsedMs), 0);

    // zero preset, on-delay
    presetMs = 8'd0; inSig = 1'b1;
    step(1);
    check("R9 on-delay zero preset q", int'(q), 1);
    inSig = 1'b0;
    step(1);

    // lowering the preset under the count
    presetMs = 8'd6; inSig = 1'b1;
    step(8);
    presetMs = 8'd2;
    step(3);
    check("R8 et holds after preset lowered", int'(elapsedMs), 6);
    check("R8 q stays done", int'(q), 1);
    inSig = 1'b0;
    step(1);

    // pulse with input held high
    mode = 2'd0; presetMs = 8'd5;
    step(1);
    inSig = 1'b1;
    cnt = 0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      cnt += int'(q);
    end
    check("R6 pulse length", cnt, 5);
    check("R7 no retrigger while held", int'(q), 0);

    // pulse with edges during the pulse
    inSig = 1'b0;
    step(2);
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      inSig = (i % 2 == 0);
      step(1);
      cnt += int'(q);
    end
    check("R7 edges during pulse ignored", cnt, 5);
    inSig = 1'b0;
    step(2);
    check("R7 et cleared at rest", int'(elapsedMs), 0);

    // zero preset pulse
    presetMs = 8'd0;
    step(1);
    inSig = 1'b1;
    cnt = 0;
    for (int i = 0; i < 3; i++) begin
      step(1);
      cnt += int'(q);
    end
    check("R9 pulse zero preset", cnt, 0);
    inSig = 1'b0;
    step(1);

    // off-delay
    mode = 2'd2; presetMs = 8'd4; inSig = 1'b1;
    step(1);
    check("R5 q follows input", int'(q), 1);
    check("R5 et clear while high", int'(elapsedMs), 0);
    inSig = 1'b0;
    step(3);
    check("R5 q still high", int'(q), 1);
    check("R5 et counting", int'(elapsedMs), 3);
    step(1);
    check("R5 q drops at preset", int'(q), 0);
    step(3);
    check("R5 et holds", int'(elapsedMs), 4);
    inSig = 1'b1;
    step(1);
    inSig = 1'b0;
    step(2);
    check("R5 count restarted", int'(elapsedMs), 2);
    inSig = 1'b1;
    step(1);
    check("R5 rise resets et", int'(elapsedMs), 0);

    // disabled
    mode = 2'd3;
    step(2);
    check("R3 idle q", int'(q), 0);
    check("R3 idle et", int'(elapsedMs), 0);
    inSig = 1'b0;
    step(1);

    // slow tick
    fastTick = 1'b0; mode = 2'd1; presetMs = 8'd100; inSig = 1'b1;
    cnt = 0;
    while (elapsedMs == 0 && cnt < 20) begin
      step(1);
      cnt++;
    end
    for (int k = 0; k < 2; k++) begin
      prevEt = int'(elapsedMs);
      cnt = 0;
      while (int'(elapsedMs) == prevEt && cnt < 40) begin
        step(1);
        cnt++;
      end
      check("R2 tick interval", cnt, DIV);
    end
    inSig = 1'b0;
    step(1);

    // mixed stimulus against the model
    for (int i = 0; i < 2000; i++) begin
      if (i % 50 == 0) mode = 2'($urandom_range(0, 3));
      if (i % 300 == 0) fastTick = ($urandom_range(0, 3) != 0);
      if (i % 40 == 0) presetMs = PT_W'($urandom_range(0, 7));
      if ($urandom_range(0, 5) == 0) inSig = ~inSig;
      step(1);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule